// File: doc/BRIEF.md
# Two-Accumulator Micro Core

This block is a very small processor core built around two 8-bit accumulators, here called `acc1` and `acc2`. It reads 6-bit instruction words from a program memory outside the block, at the address held in its program counter. It also uses a data memory outside the block through a port with one cycle of read latency. Most instructions retire in a single clock. The arithmetic and logic forms all leave their result in `acc1`. Nibble-literal forms set one half of `acc1` from the instruction word. There is no immediate branch: a conditional jump goes to the address held in `acc2`, and only when `acc1` is nonzero.

`acc2` has no arithmetic write path. It can be written only by a store to one reserved data address, the alias address (parameter `ACC2_ALIAS`, default 0). When `acc2` equals that address, a store copies `acc1` into `acc2` and does not go out to memory. A load at that address copies `acc2` into `acc1`. Any other load goes out to the data memory and stalls the core for one extra cycle while the read data returns.

The instruction input is a valid/ready stream. A word is consumed at a rising edge when `prog_valid` and `prog_ready` are both high. `prog_addr` is the word the core wants next. The source must present the word for that address, and it may hold `prog_valid` low for as long as it needs. While `prog_ready` is low, the core waits for load data; `prog_addr` stays put, so the source may keep the same word waiting. Nothing is consumed and no state changes while no word is accepted.

Top module: `duo_acc_core`

## Requirements
- R1: A synchronous reset, active high, clears the program counter, `acc1` and `acc2` to zero. In the first cycle after reset, `prog_ready` is 1.
- R2: Word 100000 writes `acc1 + acc2`, wrapped to 8 bits, into `acc1`.
- R3: Word 100001 writes the bitwise NAND of `acc1` and `acc2` into `acc1`.
- R4: Word 100010 writes the bitwise XNOR of `acc1` and `acc2` into `acc1`.
- R5: A word with bits [5:4] = 00 replaces bits [3:0] of `acc1` with the word's bits [3:0] and keeps bits [7:4] of `acc1`.
- R6: A word with bits [5:4] = 01 replaces bits [7:4] of `acc1` with the word's bits [3:0] and keeps bits [3:0] of `acc1`.
- R7: Word 110000 loads the program counter with `acc2` when `acc1` is nonzero. Otherwise it increments the program counter.
- R8: Word 111110 (store) with `acc2` not equal to `ACC2_ALIAS` raises `dmem_we` for the accepting cycle, with `dmem_addr` = `acc2` and `dmem_wdata` = `acc1`. With `acc2` equal to `ACC2_ALIAS`, the store copies `acc1` into `acc2` and raises no strobe. `acc2` changes in no other way.
- R9: Word 111111 (load) with `acc2` not equal to `ACC2_ALIAS` raises `dmem_re` with `dmem_addr` = `acc2`. In the next cycle `prog_ready` is 0, no word is consumed, and at the end of that cycle `acc1` takes `dmem_rdata`. With `acc2` equal to `ACC2_ALIAS`, the load copies `acc2` into `acc1` in one cycle and raises no strobe.
- R10: Every word not covered by R2 to R9 only increments the program counter. It changes neither accumulator and raises no strobe.
- R11: In a cycle where no word is accepted and no load is completing, the program counter and both accumulators hold.
- R12: Every accepted word other than a taken jump advances the program counter by one, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Program counter; address of the wanted instruction |
| prog_instr | input | 6 | Instruction word for `prog_addr` |
| prog_valid | input | 1 | `prog_instr` is present |
| prog_ready | output | 1 | Core can accept a word this cycle |
| dmem_addr | output | 8 | Data-memory address (always `acc2`) |
| dmem_we | output | 1 | Write strobe |
| dmem_wdata | output | 8 | Write data (always `acc1`) |
| dmem_re | output | 1 | Read strobe |
| dmem_rdata | input | 8 | Read data, due one cycle after `dmem_re` |
| dbg_pc | output | 8 | Debug copy of the program counter |
| dbg_acc1 | output | 8 | Debug copy of `acc1` |
| dbg_acc2 | output | 8 | Debug copy of `acc2` |

## Verification
The assertions take for granted that the data memory returns read data exactly one cycle after `dmem_re`. They also assume that `prog_instr` is meaningful whenever `prog_valid` is high. The load-completion property is built on that one-cycle latency. The stimulus keeps within these limits in two ways. Its memory model registers the read on the strobe edge, and it drives the stream only at falling edges, with a defined word whenever valid is high. The sweeps build every operand pair from reset, using the literal and alias-store paths. No accumulator value is ever injected by a route other than the block's own ports.

// File: rtl/duo_pkg.sv
`timescale 1ns/1ps
package duo_pkg;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 6;
  localparam int LIT_W   = 4;
  localparam int PFX_W   = INSTR_W - LIT_W;

  localparam logic [INSTR_W-1:0] OPC_ADD  = 6'b100000;
  localparam logic [INSTR_W-1:0] OPC_NAND = 6'b100001;
  localparam logic [INSTR_W-1:0] OPC_EQ   = 6'b100010;
  localparam logic [INSTR_W-1:0] OPC_CJMP = 6'b110000;
  localparam logic [INSTR_W-1:0] OPC_STR  = 6'b111110;
  localparam logic [INSTR_W-1:0] OPC_LD   = 6'b111111;
  localparam logic [PFX_W-1:0]   PFX_LO   = 2'b00;
  localparam logic [PFX_W-1:0]   PFX_HI   = 2'b01;

  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_NAND, OP_EQ, OP_CJMP, OP_STR, OP_LD, OP_LIT_LO, OP_LIT_HI
  } op_e;

  typedef enum logic {ST_RUN, ST_LDWAIT} state_e;
endpackage

// File: rtl/duo_decode.sv
`timescale 1ns/1ps
module duo_decode
  import duo_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output op_e                op,
  output logic [LIT_W-1:0]   lit
);
  assign lit = instr[LIT_W-1:0];

  always_comb begin
    op = OP_NOP;
    if (instr[INSTR_W-1 -: PFX_W] == PFX_LO) begin
      op = OP_LIT_LO;
    end else if (instr[INSTR_W-1 -: PFX_W] == PFX_HI) begin
      op = OP_LIT_HI;
    end else begin
      case (instr)
        OPC_ADD:  op = OP_ADD;
        OPC_NAND: op = OP_NAND;
        OPC_EQ:   op = OP_EQ;
        OPC_CJMP: op = OP_CJMP;
        OPC_STR:  op = OP_STR;
        OPC_LD:   op = OP_LD;
        default:  op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/duo_alu.sv
`timescale 1ns/1ps
module duo_alu
  import duo_pkg::*;
(
  input  op_e               op,
  input  logic [DATA_W-1:0] acc1,
  input  logic [DATA_W-1:0] acc2,
  input  logic [LIT_W-1:0]  lit,
  output logic [DATA_W-1:0] result,
  output logic              wr_acc1
);
  always_comb begin
    result  = acc1;
    wr_acc1 = 1'b1;
    case (op)
      OP_ADD:    result = acc1 + acc2;
      OP_NAND:   result = ~(acc1 & acc2);
      OP_EQ:     result = ~(acc1 ^ acc2);
      OP_LIT_LO: result[LIT_W-1:0] = lit;
      OP_LIT_HI: result[2*LIT_W-1:LIT_W] = lit;
      default:   wr_acc1 = 1'b0;
    endcase
  end
endmodule

// File: rtl/duo_pc.sv
`timescale 1ns/1ps
module duo_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (advance) pc <= take ? target : pc + PC_W'(1);
  end

  p_step_r12: assert property (@(posedge clk) disable iff (rst)
    (advance && !take) |=> pc == PC_W'($past(pc) + PC_W'(1)));

  p_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (advance && take) |=> pc == $past(target));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc));
endmodule

// File: rtl/duo_acc_core.sv
`timescale 1ns/1ps
module duo_acc_core
  import duo_pkg::*;
#(
  parameter logic [duo_pkg::DATA_W-1:0] ACC2_ALIAS = '0
) (
  input  logic                clk,
  input  logic                rst,
  output logic [DATA_W-1:0]   prog_addr,
  input  logic [INSTR_W-1:0]  prog_instr,
  input  logic                prog_valid,
  output logic                prog_ready,
  output logic [DATA_W-1:0]   dmem_addr,
  output logic                dmem_we,
  output logic [DATA_W-1:0]   dmem_wdata,
  output logic                dmem_re,
  input  logic [DATA_W-1:0]   dmem_rdata,
  output logic [DATA_W-1:0]   dbg_pc,
  output logic [DATA_W-1:0]   dbg_acc1,
  output logic [DATA_W-1:0]   dbg_acc2
);
  localparam int PC_W = DATA_W;

  state_e            state_q;
  logic [DATA_W-1:0] acc1_q, acc2_q;
  logic [PC_W-1:0]   pc;
  op_e               op;
  logic [LIT_W-1:0]  lit;
  logic [DATA_W-1:0] alu_res;
  logic              alu_wr;
  logic              fire, alias_hit, take;

  duo_decode u_dec (.instr(prog_instr), .op(op), .lit(lit));

  duo_alu u_alu (
    .op(op), .acc1(acc1_q), .acc2(acc2_q), .lit(lit),
    .result(alu_res), .wr_acc1(alu_wr)
  );

  assign prog_ready = (state_q == ST_RUN) && !rst;
  assign fire       = prog_valid && prog_ready;
  assign alias_hit  = (acc2_q == ACC2_ALIAS);
  assign take       = (op == OP_CJMP) && (acc1_q != '0);

  duo_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .advance(fire), .take(take),
    .target(acc2_q), .pc(pc)
  );

  assign prog_addr  = pc;
  assign dmem_addr  = acc2_q;
  assign dmem_wdata = acc1_q;
  assign dmem_we    = fire && (op == OP_STR) && !alias_hit;
  assign dmem_re    = fire && (op == OP_LD) && !alias_hit;
  assign dbg_pc     = pc;
  assign dbg_acc1   = acc1_q;
  assign dbg_acc2   = acc2_q;

  always_ff @(posedge clk) begin
    if (rst)                      state_q <= ST_RUN;
    else if (dmem_re)             state_q <= ST_LDWAIT;
    else if (state_q == ST_LDWAIT) state_q <= ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1_q <= '0;
    end else if (state_q == ST_LDWAIT) begin
      acc1_q <= dmem_rdata;
    end else if (fire) begin
      if (alu_wr)                         acc1_q <= alu_res;
      else if (op == OP_LD && alias_hit)  acc1_q <= acc2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     acc2_q <= '0;
    else if (fire && op == OP_STR && alias_hit)  acc2_q <= acc1_q;
  end

  p_acc2_only_alias_r8: assert property (@(posedge clk) disable iff (rst)
    !(fire && op == OP_STR && alias_hit) |=> $stable(acc2_q));

  p_ld_stall_r9: assert property (@(posedge clk) disable iff (rst)
    dmem_re |=> !prog_ready);

  p_ld_data_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LDWAIT) |=> (acc1_q == $past(dmem_rdata)) && prog_ready);

  p_lit_lo_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_LIT_LO) |=>
      acc1_q[DATA_W-1:LIT_W] == $past(acc1_q[DATA_W-1:LIT_W]));

  p_lit_hi_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_LIT_HI) |=>
      acc1_q[LIT_W-1:0] == $past(acc1_q[LIT_W-1:0]));

  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_NOP) |=> $stable(acc1_q) && $stable(acc2_q));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!fire && state_q == ST_RUN) |=> $stable(acc1_q) && $stable(acc2_q));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({dmem_we, dmem_re}) <= 1);
endmodule

// File: tb/duo_acc_core_tb.sv
`timescale 1ns/1ps
module duo_acc_core_tb_top;
  localparam logic [5:0] W_ADD = 6'b100000, W_NAND = 6'b100001, W_EQ = 6'b100010;
  localparam logic [5:0] W_CJMP = 6'b110000, W_STR = 6'b111110, W_LD = 6'b111111;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] prog_addr, dmem_addr, dmem_wdata, dbg_pc, dbg_acc1, dbg_acc2;
  logic [5:0] prog_instr = '0;
  logic prog_valid = 1'b0, prog_ready, dmem_we, dmem_re;
  logic [7:0] dmem_rdata = '0;
  logic [7:0] mem [256];

  int checks = 0, errors = 0;
  logic cap_we, cap_re;
  logic [7:0] cap_addr, cap_wdata;
  logic [7:0] bvals [12];

  always #5 clk = ~clk;

  duo_acc_core dut_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_instr(prog_instr),
    .prog_valid(prog_valid), .prog_ready(prog_ready), .dmem_addr(dmem_addr),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata), .dmem_re(dmem_re),
    .dmem_rdata(dmem_rdata), .dbg_pc(dbg_pc), .dbg_acc1(dbg_acc1),
    .dbg_acc2(dbg_acc2)
  );

  always @(posedge clk) begin
    if (dmem_we) mem[dmem_addr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= mem[dmem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] w);
    prog_instr = w;
    prog_valid = 1'b1;
    #1;
    cap_we = dmem_we; cap_re = dmem_re; cap_addr = dmem_addr; cap_wdata = dmem_wdata;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(dbg_pc == 0 && dbg_acc1 == 0 && dbg_acc2 == 0, "R1 state",
        {dbg_pc, dbg_acc1, dbg_acc2}, 0);
    chk(prog_ready == 1'b1, "R1 ready", prog_ready, 1);
    @(negedge clk);
  endtask

  task automatic load_acc1(input logic [7:0] v);
    issue({2'b00, v[3:0]});
    issue({2'b01, v[7:4]});
  endtask

  function automatic logic [7:0] ref_op(input int sel, input logic [7:0] a, b);
    case (sel)
      0: return a + b;
      1: return ~(a & b);
      default: return ~(a ^ b);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bvals = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hF0, 8'hFE, 8'hFF};
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    do_reset();

    for (int bi = 0; bi < 12; bi++) begin
      for (int a = 0; a < 256; a++) begin
        logic [7:0] av, bv;
        av = 8'(a);
        bv = bvals[bi];
        for (int s = 0; s < 3; s++) begin
          do_reset();
          load_acc1(bv);
          issue(W_STR);
          chk(dbg_acc2 == bv && !cap_we, "R8 alias store", dbg_acc2, bv);
          issue({2'b00, av[3:0]});
          chk(dbg_acc1 == {bv[7:4], av[3:0]}, "R5 low literal", dbg_acc1, {bv[7:4], av[3:0]});
          issue({2'b01, av[7:4]});
          chk(dbg_acc1 == av, "R6 high literal", dbg_acc1, av);
          issue(s == 0 ? W_ADD : (s == 1 ? W_NAND : W_EQ));
          chk(dbg_acc1 == ref_op(s, av, bv),
              s == 0 ? "R2 add" : (s == 1 ? "R3 nand" : "R4 xnor"),
              dbg_acc1, ref_op(s, av, bv));
          chk(dbg_pc == 8'd6, "R12 pc step", dbg_pc, 6);
        end
        do_reset();
        load_acc1(bv);
        issue(W_STR);
        load_acc1(av);
        issue(W_CJMP);
        chk(dbg_pc == ((av != 0) ? bv : 8'd6), "R7 cjmp", dbg_pc, (av != 0) ? bv : 8'd6);
      end
    end

    // R8 / R9: external store, then external load with back-pressure
    do_reset();
    load_acc1(8'h40);
    issue(W_STR);
    load_acc1(8'h9C);
    issue(W_STR);
    chk(cap_we && !cap_re && cap_addr == 8'h40 && cap_wdata == 8'h9C, "R8 ext store",
        {cap_we, cap_re, cap_addr, cap_wdata}, {2'b10, 8'h40, 8'h9C});
    chk(dbg_acc2 == 8'h40, "R8 acc2 kept", dbg_acc2, 8'h40);
    load_acc1(8'h00);
    issue(W_LD);
    chk(cap_re && !cap_we && cap_addr == 8'h40, "R9 read strobe",
        {cap_re, cap_we, cap_addr}, {2'b10, 8'h40});
    begin
      logic [7:0] pc_snap;
      pc_snap = dbg_pc;
      prog_instr = {2'b00, 4'h5};
      prog_valid = 1'b1;
      #1;
      chk(prog_ready == 1'b0, "R9 stall ready", prog_ready, 0);
      @(negedge clk);
      chk(dbg_acc1 == 8'h9C, "R9 load data", dbg_acc1, 8'h9C);
      chk(dbg_pc == pc_snap, "R9 pc held", dbg_pc, pc_snap);
      @(negedge clk);
      prog_valid = 1'b0;
      chk(dbg_acc1 == 8'h95, "R9 word taken after stall", dbg_acc1, 8'h95);
    end

    // R9 alias load
    do_reset();
    load_acc1(8'h77);
    issue(W_LD);
    chk(!cap_re && dbg_acc1 == 8'h00 && prog_ready, "R9 alias load",
        {cap_re, dbg_acc1}, 0);

    // R11 idle hold
    begin
      logic [7:0] p0, a0, b0;
      p0 = dbg_pc; a0 = dbg_acc1; b0 = dbg_acc2;
      prog_instr = W_ADD;
      repeat (5) @(negedge clk);
      chk(dbg_pc == p0 && dbg_acc1 == a0 && dbg_acc2 == b0, "R11 idle",
          {dbg_pc, dbg_acc1, dbg_acc2}, {p0, a0, b0});
    end

    // R10 undefined words
    for (int o = 32; o < 64; o++) begin
      logic [5:0] w;
      w = 6'(o);
      if (w != W_ADD && w != W_NAND && w != W_EQ && w != W_CJMP && w != W_STR && w != W_LD) begin
        do_reset();
        load_acc1(8'h5A);
        issue(W_STR);
        load_acc1(8'hC3);
        issue(w);
        chk(dbg_acc1 == 8'hC3 && dbg_acc2 == 8'h5A && dbg_pc == 8'd6 && !cap_we && !cap_re,
            "R10 undefined", {dbg_acc1, dbg_acc2, dbg_pc}, {8'hC3, 8'h5A, 8'd6});
      end
    end

    // R12 wrap
    do_reset();
    for (int i = 0; i < 256; i++) issue(6'b000000);
    chk(dbg_pc == 8'd0, "R12 pc wrap", dbg_pc, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule